// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the bus-side front end of a 1K x 8 byte-addressed non-volatile memory. It connects to a two-wire serial bus and runs on a fast system clock. Raw SCL and SDA levels are synchronised and filtered inside the block. The block answers with an open-drain pull-down enable on SDA. A transaction opens with a START and a device select byte. Write transactions carry a word address and one or more data bytes. Read transactions stream bytes out for as long as the master keeps acknowledging them.

Written bytes are held in a one-page staging buffer. The STOP that ends a write starts an internal write cycle, and the staged bytes are committed to the array when that cycle ends. While the cycle is running, every select byte is refused, so a master can poll for completion. A 10-bit read pointer survives between transactions, so a read that gives no address continues from where the last access left off.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` low) and every byte of the array reads as 8'hFF.
- R2: A select byte is acknowledged (SDA pulled low during the ninth clock) only when bits [7:4] equal 4'b1010 and bit [3] equals `strap_a2`. Otherwise the block returns no acknowledge and ignores all bytes until the next START, leaving the array unchanged.
- R3: The 10-bit memory address takes select-byte bits [2:1] as address bits [9:8] and the following word-address byte as bits [7:0]. Select bit [0] is 0 for write and 1 for read.
- R4: In a write, the block acknowledges the word address and each data byte. A STOP that follows at least one complete data byte starts an internal write cycle of `WR_CYCLES` clocks, and the data reaches the array when that cycle ends.
- R5: Within a write transaction the column address advances through the low 4 bits only, wrapping inside a 16-byte page. A 17th or later byte overwrites the earliest bytes of the same transaction.
- R6: A random read returns the byte at the given address. It is formed by a write-type select, a word address, a repeated START and a read-type select.
- R7: During a read, a master acknowledge after a byte causes the byte at the next address to be sent. The address wraps from 10'h3FF to 10'h000. A master non-acknowledge ends the output.
- R8: A read without an address (current read) returns the byte after the last byte read or written. The page bits of its select byte are not used.
- R9: While an internal write cycle runs, every select byte gets no acknowledge. The first select byte after the cycle ends is acknowledged.
- R10: A START followed by a STOP during a write transaction discards the staged data. No write cycle starts and the array is unchanged.
- R11: A STOP at any point returns the block to idle with SDA released. A START at any point, including mid-byte, restarts select-byte reception.
- R12: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks have no effect on the protocol.
- R13: The block changes `sda_oe` only while the filtered SCL is low. Input bits are taken at the rising edge of SCL, and output bits change after the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock level from the bus |
| sda_i | input | 1 | Raw serial data level from the bus |
| strap_a2 | input | 1 | Board strap compared with select-byte bit [3] |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench goes after page wrap and page overflow. A design that used the full address counter would spill writes into the next page, and one without overflow handling would keep the first bytes of an 18-byte burst. It reads across the top of the array, where a pointer held to the page bits would return the wrong byte after 10'h3FF. It exercises the pointer carried between transactions, where a design that reset or failed to advance the pointer would return the wrong byte on a current read. It also covers a START/STOP abort, which a design that committed on any STOP would turn into a spurious write cycle and a corrupted byte. Short SCL pulses injected in the middle of data bits would shift the bit count of an unfiltered design and corrupt the stored value.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int PAGE_W    = 4,
  parameter int FILT_LEN  = 4,
  parameter int WR_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_a2,
  output logic sda_oe
);
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int FC_W   = $clog2(FILT_LEN + 1);
  localparam int WC_W   = $clog2(WR_CYCLES + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_ADR, S_WR, S_RD, S_SKIP} st_t;

  logic [1:0] s1, s2, filt, filt_q;
  logic [FC_W-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
      filt <= 2'b11;
      filt_q <= 2'b11;
      for (int g = 0; g < 2; g++) fcnt[g] <= '0;
    end else begin
      s1 <= {scl_i, sda_i};
      s2 <= s1;
      filt_q <= filt;
      for (int g = 0; g < 2; g++)
        if (s2[g] == filt[g]) fcnt[g] <= '0;
        else if (fcnt[g] == FC_W'(FILT_LEN - 1)) begin
          filt[g] <= s2[g];
          fcnt[g] <= '0;
        end else fcnt[g] <= fcnt[g] + 1'b1;
    end

  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_f    = filt[1];
  assign sda_f    = filt[0];
  assign scl_rise = scl_f & ~filt_q[1];
  assign scl_fall = ~scl_f & filt_q[1];
  assign start_ev = scl_f & filt_q[1] & filt_q[0] & ~sda_f;
  assign stop_ev  = scl_f & filt_q[1] & ~filt_q[0] & sda_f;

  st_t st, st_nx;
  logic [3:0] cnt;
  logic [6:0] sr;
  logic [7:0] tx;
  logic ack_p;
  logic [1:0] pg;
  logic [ADDR_W-1:0] ptr;
  logic [BASE_W-1:0] wbase;
  logic [PAGE_W-1:0] widx;
  logic [PAGE-1:0] pval;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];
  logic busy;
  logic [WC_W-1:0] wcnt;

  logic [7:0] byte_in;
  logic sel_ok, wr_byte, commit;
  assign byte_in = {sr, sda_f};
  assign sel_ok  = (byte_in[7:4] == DEV_CODE) && (byte_in[3] == strap_a2);
  assign wr_byte = scl_rise && st == S_WR && cnt == 4'd7;
  assign commit  = busy && wcnt == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      st_nx <= S_IDLE;
      cnt <= '0;
      sr <= '0;
      tx <= '0;
      ack_p <= 1'b0;
      pg <= '0;
      ptr <= '0;
      wbase <= '0;
      widx <= '0;
      pval <= '0;
      busy <= 1'b0;
      wcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (busy) begin
        if (commit) begin
          busy <= 1'b0;
          pval <= '0;
        end else wcnt <= wcnt - 1'b1;
      end
      if (stop_ev) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        if (st == S_WR && |pval && !busy) begin
          busy <= 1'b1;
          wcnt <= WC_W'(WR_CYCLES - 1);
        end
      end else if (start_ev) begin
        st <= S_SEL;
        cnt <= '0;
        sda_oe <= 1'b0;
        if (!busy) pval <= '0;
      end else if (scl_rise) begin
        if (st == S_SEL || st == S_ADR || st == S_WR) begin
          if (cnt < 4'd8) begin
            sr <= byte_in[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              ack_p <= 1'b0;
              st_nx <= S_SKIP;
              case (st)
                S_SEL: if (sel_ok && !busy) begin
                  ack_p <= 1'b1;
                  pg <= byte_in[2:1];
                  st_nx <= byte_in[0] ? S_RD : S_ADR;
                end
                S_ADR: begin
                  ack_p <= 1'b1;
                  st_nx <= S_WR;
                  ptr <= {pg, byte_in};
                  wbase <= {pg, byte_in[7:PAGE_W]};
                  widx <= byte_in[PAGE_W-1:0];
                end
                S_WR: begin
                  ack_p <= 1'b1;
                  st_nx <= S_WR;
                  pval[widx] <= 1'b1;
                  widx <= widx + 1'b1;
                  ptr <= {wbase, PAGE_W'(widx + 1'b1)};
                end
                default: ;
              endcase
            end
          end else begin
            cnt <= '0;
            st <= st_nx;
            if (st_nx == S_RD) begin
              tx <= mem[ptr];
              ptr <= ptr + 1'b1;
            end
          end
        end else if (st == S_RD) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            tx <= {tx[6:0], 1'b0};
          end else begin
            cnt <= '0;
            if (!sda_f) begin
              tx <= mem[ptr];
              ptr <= ptr + 1'b1;
            end else st <= S_SKIP;
          end
        end
      end else if (scl_fall) begin
        if ((st == S_SEL || st == S_ADR || st == S_WR) && cnt == 4'd8) sda_oe <= ack_p;
        else if (st == S_RD && cnt < 4'd8) sda_oe <= ~tx[7];
        else sda_oe <= 1'b0;
      end
    end

  always_ff @(posedge clk)
    if (wr_byte) pbuf[widx] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{wbase, PAGE_W'(i)}] <= pbuf[i];
    end
endmodule

module i2c_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic busy,
  input logic sda_oe,
  input logic [2:0] st,
  input logic [3:0] cnt
);
  // R13
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && st == 3'd0));
  // R11
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (st == 3'd1 && cnt == 4'd0 && !sda_oe));
  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R4
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_ev(start_ev), .stop_ev(stop_ev),
  .busy(busy), .sda_oe(sda_oe), .st(st), .cnt(cnt));

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int Q = 10;
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {10'h000, 8'h5A}, {10'h155, 8'hA7}, {10'h2AA, 8'h3D},
    {10'h3FF, 8'hC3}, {10'h180, 8'h81}, {10'h07F, 8'hF0}};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  i2c_eeprom_slave i_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_a2(1'b1), .sda_oe(sda_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sel(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b1, a[9:8], rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    m_sda = b; wq(Q); m_scl = 1'b1;
    if (glitch) begin
      wq(Q); m_scl = 1'b0; wq(2); m_scl = 1'b1; wq(Q);
    end else wq(2 * Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic tx_byte(input logic [7:0] d, input logic glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rx_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack, 1'b0);
  endtask

  task automatic send_chk(input string req, input logic [7:0] d, input logic exp_ack);
    logic a;
    tx_byte(d, 1'b0, a);
    check(req, a, exp_ack);
  endtask

  task automatic poll(input string req, input logic exp_wait);
    logic a;
    int n;
    n = 0;
    do begin
      bus_start();
      tx_byte(sel(10'h0, 1'b0), 1'b0, a);
      n++;
    end while (!a && n < 40);
    bus_stop();
    check(req, a, 1'b1);
    check(req, (n > 1), exp_wait);
  endtask

  task automatic write_one(input string req, input logic [9:0] a, input logic [7:0] d);
    bus_start();
    send_chk(req, sel(a, 1'b0), 1'b1);
    send_chk(req, a[7:0], 1'b1);
    send_chk(req, d, 1'b1);
    bus_stop();
    poll(req, 1'b1);
  endtask

  task automatic rd_rand(input string req, input logic [9:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_start();
    send_chk(req, sel(a, 1'b0), 1'b1);
    send_chk(req, a[7:0], 1'b1);
    bus_start();
    send_chk(req, sel(a, 1'b1), 1'b1);
    rx_byte(d, 1'b0);
    bus_stop();
    check(req, d, exp);
  endtask

  task automatic rd_cur(input string req, input logic [7:0] exp);
    logic [7:0] d;
    bus_start();
    send_chk(req, sel(10'h300, 1'b1), 1'b1);
    rx_byte(d, 1'b0);
    bus_stop();
    check(req, d, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] d;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    check("R1 sda released after reset", sda_oe, 1'b0);
    rd_rand("R1 erased byte", 10'h200, 8'hFF);

    // R3 R4 R6 R9: table of address/data pairs, byte write then random read
    for (int i = 0; i < NV; i++) begin
      write_one("R4 byte write", VEC[i][17:8], VEC[i][7:0]);
      rd_rand("R3 R6 readback", VEC[i][17:8], VEC[i][7:0]);
    end

    // R2: wrong strap bit and wrong device code
    bus_start();
    send_chk("R2 strap mismatch nack", {4'b1010, 1'b0, 2'b00, 1'b0}, 1'b0);
    send_chk("R2 ignored byte", 8'h10, 1'b0);
    send_chk("R2 ignored byte", 8'h99, 1'b0);
    bus_stop();
    bus_start();
    send_chk("R2 code mismatch nack", {4'b1011, 1'b1, 2'b00, 1'b0}, 1'b0);
    bus_stop();
    rd_rand("R2 array untouched", 10'h010, 8'hFF);

    // R5: page wrap inside 16 bytes
    bus_start();
    send_chk("R5 page write", sel(10'h12E, 1'b0), 1'b1);
    send_chk("R5 page write", 8'h2E, 1'b1);
    for (int k = 0; k < 3; k++) send_chk("R5 page write", 8'hE0 + 8'(k), 1'b1);
    bus_stop();
    poll("R5 poll", 1'b1);
    rd_rand("R5 first byte", 10'h12E, 8'hE0);
    rd_cur("R5 second byte", 8'hE1);
    rd_rand("R5 wrapped byte", 10'h120, 8'hE2);
    rd_rand("R5 next page untouched", 10'h130, 8'hFF);

    // R5 R7: 18-byte burst overwrites first two, sequential read back
    bus_start();
    send_chk("R5 overflow write", sel(10'h240, 1'b0), 1'b1);
    send_chk("R5 overflow write", 8'h40, 1'b1);
    for (int k = 0; k < 18; k++) send_chk("R5 overflow write", 8'h30 + 8'(k), 1'b1);
    bus_stop();
    poll("R5 overflow poll", 1'b1);
    bus_start();
    send_chk("R7 seq read", sel(10'h240, 1'b0), 1'b1);
    send_chk("R7 seq read", 8'h40, 1'b1);
    bus_start();
    send_chk("R7 seq read", sel(10'h240, 1'b1), 1'b1);
    for (int k = 0; k < 16; k++) begin
      rx_byte(d, k < 15);
      check("R5 R7 sequential byte", d, (k < 2) ? 8'h40 + 8'(k) : 8'h30 + 8'(k));
    end
    bus_stop();

    // R7: wrap from top of array
    bus_start();
    send_chk("R7 wrap read", sel(10'h3FF, 1'b0), 1'b1);
    send_chk("R7 wrap read", 8'hFF, 1'b1);
    bus_start();
    send_chk("R7 wrap read", sel(10'h3FF, 1'b1), 1'b1);
    rx_byte(d, 1'b1);
    check("R7 top byte", d, 8'hC3);
    rx_byte(d, 1'b0);
    check("R7 wrapped to zero", d, 8'h5A);
    bus_stop();
    rd_cur("R8 after wrap read", 8'hFF);

    // R8: pointer after write and after read
    write_one("R8 setup", 10'h3B6, 8'h66);
    write_one("R8 setup", 10'h3B5, 8'h99);
    rd_cur("R8 current after write", 8'h66);
    rd_rand("R8 setup read", 10'h3B5, 8'h99);
    rd_cur("R8 current after read", 8'h66);

    // R10: START then STOP discards staged data
    bus_start();
    send_chk("R10 abort", sel(10'h050, 1'b0), 1'b1);
    send_chk("R10 abort", 8'h50, 1'b1);
    send_chk("R10 abort", 8'hAB, 1'b1);
    bus_start();
    bus_stop();
    poll("R10 no write cycle", 1'b0);
    rd_rand("R10 array unchanged", 10'h050, 8'hFF);

    // R11: START mid-byte restarts select, STOP releases
    bus_start();
    send_chk("R11 setup", sel(10'h155, 1'b0), 1'b1);
    send_chk("R11 setup", 8'h55, 1'b1);
    bus_start();
    put_bit(1'b1, 1'b0);
    put_bit(1'b0, 1'b0);
    put_bit(1'b1, 1'b0);
    bus_start();
    send_chk("R11 restart select ack", sel(10'h155, 1'b1), 1'b1);
    rx_byte(d, 1'b0);
    check("R11 read after restart", d, 8'hA7);
    bus_stop();
    wq(2);
    check("R11 sda released after stop", sda_oe, 1'b0);

    // R12: short SCL pulses inside each data bit
    bus_start();
    send_chk("R12 glitch write", sel(10'h0A5, 1'b0), 1'b1);
    send_chk("R12 glitch write", 8'hA5, 1'b1);
    tx_byte(8'h3C, 1'b1, a);
    check("R12 glitch byte ack", a, 1'b1);
    bus_stop();
    poll("R12 poll", 1'b1);
    rd_rand("R12 glitch data intact", 10'h0A5, 8'h3C);

    summary();
  end
endmodule